// File: doc/BRIEF.md
# I2C SCL Rate Divider

This block turns the system clock into the timing grid used by an I2C master sequencer. A 7-bit baud word carries an exponent and a mantissa. The block emits a one-cycle clock-enable, called `tick_o`, once every (M+1)·2^N system clock cycles. That tick runs at ten times the SCL rate, so the resulting SCL frequency is f_clk / (10·(M+1)·2^N).

The divider is built from two stages. The first is a binary prescaler that divides by 2^N. The second is a linear counter that divides the prescaler output by M+1. A ten-step phase sequencer follows them. It drives the SCL level low for five ticks and then high for five ticks. In the middle of the low half it gives a one-cycle strobe, which marks where SDA may change.

A written baud word is held as pending. It becomes active only at a tick boundary, so a divide interval that is already running is never cut short or stretched.

Top module: `i2c_scl_rate_div`

## Requirements
- R1: The baud word splits into an exponent N in bits 2:0 and a mantissa M in bits 6:3. With that word active, ticks occur exactly (M+1)·2^N clock cycles apart, for every one of the 128 values.
- R2: `tick_o` is high for exactly one cycle per interval. When the interval is one cycle long, it is high on every cycle.
- R3: After reset the active baud word is 0x44, which gives M=8 and N=4. The first tick is high after the 143rd rising edge that samples reset inactive, and later ticks are 144 cycles apart.
- R4: A write counts from its own clock edge. The interval in progress at that edge is not changed. The new word governs every interval that starts at a tick after that edge. In particular, a write made in a tick cycle first applies one interval later.
- R5: `scl_o` is low after reset and changes only in the cycle after a tick. Counting ticks from the first one after reset as index 0, `scl_o` during tick i is low when i mod 10 is below 5 and high otherwise.
- R6: `sda_strobe_o` is high only together with a tick whose index mod 10 is 2, that is, in the middle of the low half.
- R7: When several writes arrive within one interval, the last one is the word that becomes active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_we | input | 1 | Write strobe for the baud word |
| baud_wdata | input | 7 | Baud word: mantissa in bits 6:3, exponent in bits 2:0 |
| tick_o | output | 1 | One-cycle enable at ten times the SCL rate |
| scl_o | output | 1 | SCL level from the phase sequencer |
| sda_strobe_o | output | 1 | One-cycle pulse in the middle of the SCL low half |

## Verification
The bench samples every output on the falling clock edge and measures time as the number of falling edges between two ticks. With that convention, a tick interval is due after exactly (M+1)·2^N samples, and the first tick after reset is due at sample 143.

Each write is placed in a known cycle: either in a tick cycle or 50 cycles into an interval. The bench then expects the old period for the running interval and the new period for the next one.

The phase outputs are checked only in tick cycles, against the tick index mod 10. The strobe is also checked to stay low on every cycle between ticks.

// File: rtl/i2c_rate_pkg.sv
// Package: shared defaults for the I2C SCL rate divider.
// Assumes one fixed layout for the baud word: the mantissa sits above the exponent.
package i2c_rate_pkg;
    localparam int         RATE_M_W   = 4;        // mantissa field width
    localparam int         RATE_N_W   = 3;        // exponent field width
    localparam logic [6:0] RATE_RESET = 7'h44;    // baud word after reset
    localparam int         RATE_PHASES = 10;      // ticks per SCL period
endpackage

// File: rtl/i2c_rate_cfg.sv
// Module: baud word holding stage.
// A write is captured into a pending register. The active word copies the pending
// word only when load is high, which the top drives with the tick.
// Assumes load is a single-cycle pulse.
module i2c_rate_cfg #(
    parameter int              BAUD_W     = 7,
    parameter logic [BAUD_W-1:0] RESET_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [BAUD_W-1:0] wdata,
    input  logic              load,
    output logic [BAUD_W-1:0] pend_q,
    output logic [BAUD_W-1:0] active_q
);
    // Capture the latest written word.
    always_ff @(posedge clk) begin
        if (!rst_n)  pend_q <= RESET_VAL;
        else if (we) pend_q <= wdata;
    end

    // Move the pending word into service at the interval boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)    active_q <= RESET_VAL;
        else if (load) active_q <= pend_q;
    end
endmodule

// File: rtl/i2c_rate_prescale.sv
// Module: binary prescaler.
// Raises step_o for one cycle in every 2^expo cycles.
// Assumes a change of expo happens only at a tick, when the counter has just wrapped
// to zero.
module i2c_rate_prescale #(
    parameter int N_W = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N_W-1:0] expo,
    output logic           step_o
);
    localparam int PW = (1 << N_W) - 1;

    logic [PW-1:0] cnt;
    logic [PW-1:0] mask;

    // Terminal count is 2^expo - 1, taken from a shifted ones mask.
    always_comb begin
        mask   = ~({PW{1'b1}} << expo);
        step_o = (cnt == mask);
    end

    // Count up to the terminal value, then wrap to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (step_o) cnt <= '0;
        else             cnt <= cnt + PW'(1);
    end
endmodule

// File: rtl/i2c_rate_mant.sv
// Module: linear mantissa divider.
// Counts prescaler steps and raises tick_o on step number mant+1.
// Assumes mant changes only in the cycle after a tick.
module i2c_rate_mant #(
    parameter int M_W = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [M_W-1:0] mant,
    input  logic           step,
    output logic           tick_o
);
    logic [M_W-1:0] cnt;

    // A tick is the last prescaler step of the interval.
    always_comb tick_o = step && (cnt == mant);

    // Advance on each step and restart at the tick.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (tick_o) cnt <= '0;
        else if (step)   cnt <= cnt + M_W'(1);
    end
endmodule

// File: rtl/i2c_rate_phase.sv
// Module: ten-step SCL phase sequencer.
// The first half of the period holds SCL low and the second half holds it high.
// The SDA strobe marks the tick in the middle of the low half.
// Assumes PHASES is even and at least 4.
module i2c_rate_phase #(
    parameter int PHASES = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic scl_o,
    output logic strobe_o
);
    localparam int PH_W    = $clog2(PHASES);
    localparam int HALF    = PHASES / 2;
    localparam int MID_LOW = HALF / 2;

    logic [PH_W-1:0] ph;

    // Decode the SCL level and the mid-low strobe from the phase.
    always_comb begin
        scl_o    = (ph >= PH_W'(HALF));
        strobe_o = tick && (ph == PH_W'(MID_LOW));
    end

    // Step the phase once per tick, wrapping after the last step.
    always_ff @(posedge clk) begin
        if (!rst_n)     ph <= '0;
        else if (tick)  ph <= (ph == PH_W'(PHASES - 1)) ? '0 : ph + PH_W'(1);
    end
endmodule

// File: rtl/i2c_scl_rate_div.sv
// Module: I2C SCL rate divider top.
// Ticks at f_clk / ((M+1)*2^N) and derives the SCL level and the SDA strobe from them.
// Assumes the baud word is M in bits [BAUD_W-1:N_W] and N in bits [N_W-1:0].
module i2c_scl_rate_div
    import i2c_rate_pkg::*;
#(
    parameter int M_W    = RATE_M_W,
    parameter int N_W    = RATE_N_W,
    parameter int PHASES = RATE_PHASES,
    parameter logic [M_W+N_W-1:0] RESET_BAUD = RATE_RESET
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               baud_we,
    input  logic [M_W+N_W-1:0] baud_wdata,
    output logic               tick_o,
    output logic               scl_o,
    output logic               sda_strobe_o
);
    localparam int BAUD_W = M_W + N_W;

    logic [BAUD_W-1:0] pend_baud;
    logic [BAUD_W-1:0] active_baud;
    logic              pre_step;
    logic              tick;

    i2c_rate_cfg #(.BAUD_W(BAUD_W), .RESET_VAL(RESET_BAUD)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(baud_we), .wdata(baud_wdata),
        .load(tick), .pend_q(pend_baud), .active_q(active_baud)
    );

    i2c_rate_prescale #(.N_W(N_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .expo(active_baud[N_W-1:0]), .step_o(pre_step)
    );

    i2c_rate_mant #(.M_W(M_W)) u_mant (
        .clk(clk), .rst_n(rst_n), .mant(active_baud[BAUD_W-1:N_W]),
        .step(pre_step), .tick_o(tick)
    );

    i2c_rate_phase #(.PHASES(PHASES)) u_phase (
        .clk(clk), .rst_n(rst_n), .tick(tick), .scl_o(scl_o), .strobe_o(sda_strobe_o)
    );

    assign tick_o = tick;
endmodule

// File: rtl/i2c_scl_rate_div_checker.sv
// Module: property checker for the SCL rate divider, attached to the top by bind.
// Assumes reset is synchronous and active low.
module i2c_scl_rate_div_checker #(
    parameter int BAUD_W = 7,
    parameter logic [BAUD_W-1:0] RESET_BAUD = 7'h44
) (
    input logic              clk,
    input logic              rst_n,
    input logic              baud_we,
    input logic [BAUD_W-1:0] baud_wdata,
    input logic              tick,
    input logic              scl,
    input logic              strobe,
    input logic [BAUD_W-1:0] pend,
    input logic [BAUD_W-1:0] active
);
    // R3: the active word leaves reset at the default value.
    assert_reset_baud_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (active == RESET_BAUD));

    // R4: the active word changes only at a tick boundary.
    assert_cfg_at_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(active));

    // R5: SCL moves only in the cycle after a tick.
    assert_scl_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(scl));

    // R6: the SDA strobe falls inside a tick, during the low half.
    assert_strobe_mid_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> (tick && !scl));

    // R7: every write lands in the pending word.
    assert_last_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        baud_we |=> (pend == $past(baud_wdata)));
endmodule

bind i2c_scl_rate_div i2c_scl_rate_div_checker #(
    .BAUD_W(M_W + N_W), .RESET_BAUD(RESET_BAUD)
) u_chk (
    .clk(clk), .rst_n(rst_n), .baud_we(baud_we), .baud_wdata(baud_wdata),
    .tick(tick_o), .scl(scl_o), .strobe(sda_strobe_o),
    .pend(pend_baud), .active(active_baud)
);

// File: tb/i2c_scl_rate_div_bench.sv
module i2c_scl_rate_div_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_we = 1'b0;
    logic [6:0] baud_wdata = '0;
    logic       tick_o, scl_o, sda_strobe_o;

    int  total = 0;
    int  bad = 0;
    bit  done = 1'b0;

    always #10 clk = ~clk;

    i2c_scl_rate_div u_i2c_scl_rate_div (
        .clk(clk), .rst_n(rst_n), .baud_we(baud_we), .baud_wdata(baud_wdata),
        .tick_o(tick_o), .scl_o(scl_o), .sda_strobe_o(sda_strobe_o)
    );

    function automatic int period_of(input logic [6:0] b);
        return (int'(b[6:3]) + 1) << b[2:0];
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Counts falling edges until the next tick; the caller stands on a tick sample.
    task automatic wait_tick(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!tick_o);
    endtask

    initial begin
        int n;
        int cnt;
        logic [6:0] prev;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(tick_o == 1'b0 && scl_o == 1'b0 && sda_strobe_o == 1'b0, "R5 reset outputs",
            {tick_o, scl_o, sda_strobe_o}, 0);
        rst_n = 1'b1;

        // R3: first tick after reset, using the default word 0x44.
        wait_tick(n);
        chk(n == 143, "R3 first tick", n, 143);

        // R5 / R6: phase pattern over two SCL periods; R3: period at reset value.
        for (int i = 0; i < 20; i++) begin
            chk(scl_o == ((i % 10) >= 5), "R5 scl at tick", scl_o, int'((i % 10) >= 5));
            chk(sda_strobe_o == ((i % 10) == 2), "R6 strobe at tick", sda_strobe_o,
                int'((i % 10) == 2));
            cnt = 0;
            do begin
                @(negedge clk);
                cnt++;
                if (!tick_o) chk(sda_strobe_o == 1'b0, "R6 strobe off-tick", sda_strobe_o, 0);
            end while (!tick_o);
            chk(cnt == 144, "R3 default period", cnt, 144);
        end

        // R4 / R7: two writes in the middle of an interval; the last one wins.
        cnt = 0;
        for (int k = 0; k < 50; k++) begin
            @(negedge clk);
            cnt++;
        end
        baud_we = 1'b1;
        baud_wdata = 7'h7F;
        @(negedge clk);
        cnt++;
        baud_wdata = 7'h01;
        @(negedge clk);
        cnt++;
        baud_we = 1'b0;
        wait_tick(n);
        chk(cnt + n == 144, "R4 running interval kept", cnt + n, 144);
        wait_tick(n);
        chk(n == 2, "R7 last write active", n, 2);
        prev = 7'h01;

        // R1 / R2 / R4: sweep all words, each written in a tick cycle.
        for (int b = 0; b < 128; b++) begin
            baud_we = 1'b1;
            baud_wdata = 7'(b);
            @(negedge clk);
            baud_we = 1'b0;
            n = 1;
            while (!tick_o) begin
                @(negedge clk);
                n++;
            end
            chk(n == period_of(prev), "R4 write in tick cycle", n, period_of(prev));
            wait_tick(n);
            chk(n == period_of(7'(b)), "R1 period", n, period_of(7'(b)));
            if (period_of(7'(b)) > 1) begin
                @(negedge clk);
                chk(tick_o == 1'b0, "R2 single-cycle tick", tick_o, 0);
                wait_tick(n);
                chk(n == period_of(7'(b)) - 1, "R2 next tick", n, period_of(7'(b)) - 1);
            end else begin
                @(negedge clk);
                chk(tick_o == 1'b1, "R2 tick every cycle", tick_o, 1);
            end
            prev = 7'(b);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule